// File: doc/BRIEF.md
# Critical Sub-Block Priority Request Splitter

This block sits between a last-level cache miss path and a memory controller. Each cache-line fill request it accepts is broken into fixed-size sub-block memory requests. The sub-block that holds the byte the processor is waiting for is marked critical, so it reaches memory ahead of the rest of the line. A small table of outstanding lines records, for every sub-block, whether it is marked critical, whether it has been issued and whether it has come back.

Several lines may be in flight at once, and their sub-blocks may return in any order. A later miss that falls on a line already in the table does not open a new entry. If the sub-block it wants has not been issued yet, that sub-block is promoted to critical. Each returned sub-block is forwarded to the requester on its own, with its line address and sub-block index, without waiting for the rest of the line.

The sub-block size parameter is meant to be at least 16 bytes, which is the smallest request the memory side can serve. The line size must be a whole multiple of it.

Top module: `subblock_prio_splitter`

## Requirements
- R1: Every accepted new line yields exactly NSUB sub-block requests. Each is issued once, on a cycle with `req_valid` and `req_ready` both high. Each carries `req_tag` = {entry index in the upper ENT_W bits, sub-block index in the lower SUB_W bits}.
- R2: The critical sub-block index is `miss_off / SUB_BYTES`. That sub-block is issued with `req_crit`=1 before any sub-block with `req_crit`=0 is issued.
- R3: Whenever any unissued critical sub-block is pending, a critical one is offered. Within one class, the entry allocated earliest goes first. Within one entry, the lowest sub-block index goes first.
- R4: A miss whose line matches a valid entry is accepted (`miss_ready`=1) and opens no new entry. If its sub-block is still unissued, that sub-block becomes critical. If it is already issued, nothing changes.
- R5: A miss to a line that is not in the table is placed in the lowest-numbered free entry.
- R6: One cycle after a clock edge with `ret_valid`=1, `out_valid`=1. At that point `out_line` is the entry's line, `out_sub` is the tag's sub-block index and `out_data` equals `ret_data`. With no return on an edge, `out_valid` is 0 in the next cycle.
- R7: An entry is freed on the edge that records its last of NSUB returns, whatever the return order. Returns of different lines may interleave.
- R8: When every entry is valid and the offered line matches none of them, `miss_ready` is 0 and the miss is held off.
- R9: After reset the table is empty. `req_valid`=0, `out_valid`=0 and `miss_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request offered |
| miss_ready | output | 1 | Miss request can be taken this cycle |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_off | input | OFF_W | Byte offset of the wanted word within the line |
| req_valid | output | 1 | Sub-block request offered to memory |
| req_ready | input | 1 | Memory side takes the request |
| req_line | output | LINE_AW | Line address of the request |
| req_sub | output | SUB_W | Sub-block index of the request |
| req_crit | output | 1 | Request is critical |
| req_tag | output | TAG_W | {entry, sub-block} tag |
| ret_valid | input | 1 | Sub-block data returned from memory |
| ret_tag | input | TAG_W | Tag of the returned sub-block |
| ret_data | input | DATA_W | Returned sub-block data |
| out_valid | output | 1 | Sub-block delivered to requester |
| out_line | output | LINE_AW | Line address of delivered sub-block |
| out_sub | output | SUB_W | Sub-block index of delivered sub-block |
| out_data | output | DATA_W | Delivered sub-block data |

## Verification
The bench builds the block with its defaults. These are a 64-byte line of four 16-byte sub-blocks and a four-entry table, so the whole 4-bit tag space can be in flight at once. That size lets one test fill the table, hold off a fifth line, and merge a promotion into a pending line. The same test then drains all sixteen requests in the exact order set by class, age and index. Freeing one entry out of order and watching the held-off line take that freed slot checks allocation and the retire condition together.

// File: rtl/csb_pkg.sv
package csb_pkg;

  // Index of the sub-block that contains a byte offset within the line.
  function automatic int sub_of_offset(int byte_off, int sub_bytes);
    return byte_off / sub_bytes;
  endfunction

  // Position of the least significant set bit (0 when none is set).
  function automatic int lowest_set(logic [31:0] vec);
    for (int k = 0; k < 32; k++) begin
      if (vec[k]) return k;
    end
    return 0;
  endfunction

endpackage

// File: rtl/csb_mshr.sv
module csb_mshr #(
  parameter int LINE_AW = 26,
  parameter int ENTRIES = 4,
  parameter int NSUB    = 4,
  localparam int ENT_W  = $clog2(ENTRIES),
  localparam int SUB_W  = $clog2(NSUB)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [LINE_AW-1:0]                lookup_line,
  input  logic                              alloc_en,
  input  logic [SUB_W-1:0]                  alloc_sub,
  input  logic                              merge_en,
  input  logic [ENT_W-1:0]                  merge_idx,
  input  logic [SUB_W-1:0]                  merge_sub,
  input  logic                              issue_en,
  input  logic [ENT_W-1:0]                  issue_idx,
  input  logic [SUB_W-1:0]                  issue_sub,
  input  logic                              ret_en,
  input  logic [ENT_W-1:0]                  ret_idx,
  input  logic [SUB_W-1:0]                  ret_sub,
  output logic [ENTRIES-1:0]                ent_valid,
  output logic [ENTRIES-1:0][LINE_AW-1:0]   ent_line,
  output logic [ENTRIES-1:0][NSUB-1:0]      ent_issued,
  output logic [ENTRIES-1:0][NSUB-1:0]      ent_crit,
  output logic [ENTRIES-1:0][ENTRIES-1:0]   ent_older,
  output logic                              line_hit,
  output logic [ENT_W-1:0]                  hit_idx,
  output logic                              have_free,
  output logic [ENT_W-1:0]                  free_idx
);

  logic [ENTRIES-1:0]              valid_q;
  logic [ENTRIES-1:0][LINE_AW-1:0] line_q;
  logic [ENTRIES-1:0][NSUB-1:0]    issued_q;
  logic [ENTRIES-1:0][NSUB-1:0]    crit_q;
  logic [ENTRIES-1:0][NSUB-1:0]    done_q;
  logic [ENTRIES-1:0][ENTRIES-1:0] older_q;   // older_q[a][b]: a allocated before b
  logic                            last_return;

  // Associative lookup and lowest free slot; descending scan lets the lowest index win.
  always_comb begin
    line_hit  = 1'b0;
    hit_idx   = '0;
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid_q[i] && line_q[i] == lookup_line) begin
        line_hit = 1'b1;
        hit_idx  = ENT_W'(i);
      end
      if (!valid_q[i]) begin
        have_free = 1'b1;
        free_idx  = ENT_W'(i);
      end
    end
  end

  assign last_return = ret_en &&
    ((done_q[ret_idx] | (NSUB'(1) << ret_sub)) == {NSUB{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      line_q   <= '0;
      issued_q <= '0;
      crit_q   <= '0;
      done_q   <= '0;
      older_q  <= '0;
    end else begin
      if (issue_en) issued_q[issue_idx][issue_sub] <= 1'b1;
      if (merge_en && !issued_q[merge_idx][merge_sub])
        crit_q[merge_idx][merge_sub] <= 1'b1;
      if (ret_en) begin
        done_q[ret_idx][ret_sub] <= 1'b1;
        if (last_return) valid_q[ret_idx] <= 1'b0;
      end
      if (alloc_en) begin
        valid_q[free_idx]  <= 1'b1;
        line_q[free_idx]   <= lookup_line;
        issued_q[free_idx] <= '0;
        done_q[free_idx]   <= '0;
        crit_q[free_idx]   <= NSUB'(1) << alloc_sub;
        for (int j = 0; j < ENTRIES; j++) older_q[j][free_idx] <= 1'b1;
        older_q[free_idx] <= '0;
      end
    end
  end

  assign ent_valid  = valid_q;
  assign ent_line   = line_q;
  assign ent_issued = issued_q;
  assign ent_crit   = crit_q;
  assign ent_older  = older_q;

endmodule

// File: rtl/csb_pick.sv
module csb_pick #(
  parameter int ENTRIES = 4,
  parameter int NSUB    = 4,
  localparam int ENT_W  = $clog2(ENTRIES),
  localparam int SUB_W  = $clog2(NSUB)
) (
  input  logic [ENTRIES-1:0]              ent_valid,
  input  logic [ENTRIES-1:0][NSUB-1:0]    ent_issued,
  input  logic [ENTRIES-1:0][NSUB-1:0]    ent_crit,
  input  logic [ENTRIES-1:0][ENTRIES-1:0] ent_older,
  output logic                            pick_valid,
  output logic [ENT_W-1:0]                pick_idx,
  output logic [SUB_W-1:0]                pick_sub,
  output logic                            pick_crit
);
  import csb_pkg::*;

  logic [ENTRIES-1:0][NSUB-1:0] pend;
  logic [ENTRIES-1:0][NSUB-1:0] crit_pend;
  logic [ENTRIES-1:0]           cand;
  logic [ENTRIES-1:0]           win;
  logic                         any_crit;
  logic [NSUB-1:0]              mask;

  assign any_crit = |crit_pend;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic oldest;
    assign pend[i]      = ent_valid[i] ? ~ent_issued[i] : '0;
    assign crit_pend[i] = pend[i] & ent_crit[i];
    assign cand[i]      = any_crit ? |crit_pend[i] : |pend[i];
    always_comb begin
      oldest = cand[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && cand[j] && ent_older[j][i]) oldest = 1'b0;
      end
    end
    assign win[i] = oldest;
  end

  always_comb begin
    pick_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (win[i]) pick_idx = ENT_W'(i);
    end
    mask     = any_crit ? crit_pend[pick_idx] : pend[pick_idx];
    pick_sub = SUB_W'(lowest_set(32'(mask)));
  end

  assign pick_valid = |cand;
  assign pick_crit  = any_crit;

endmodule

// File: rtl/csb_retpath.sv
module csb_retpath #(
  parameter int LINE_AW = 26,
  parameter int SUB_W   = 2,
  parameter int DATA_W  = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ret_en,
  input  logic [LINE_AW-1:0] ret_line,
  input  logic [SUB_W-1:0]   ret_sub,
  input  logic [DATA_W-1:0]  ret_data,
  output logic               out_valid,
  output logic [LINE_AW-1:0] out_line,
  output logic [SUB_W-1:0]   out_sub,
  output logic [DATA_W-1:0]  out_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_line  <= '0;
      out_sub   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= ret_en;
      if (ret_en) begin
        out_line <= ret_line;
        out_sub  <= ret_sub;
        out_data <= ret_data;
      end
    end
  end

endmodule

// File: rtl/subblock_prio_splitter.sv
module subblock_prio_splitter #(
  parameter int LINE_AW    = 26,
  parameter int LINE_BYTES = 64,
  parameter int SUB_BYTES  = 16,
  parameter int ENTRIES    = 4,
  localparam int NSUB      = LINE_BYTES / SUB_BYTES,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SUB_W     = $clog2(NSUB),
  localparam int ENT_W     = $clog2(ENTRIES),
  localparam int TAG_W     = ENT_W + SUB_W,
  localparam int DATA_W    = SUB_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [OFF_W-1:0]   miss_off,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [LINE_AW-1:0] req_line,
  output logic [SUB_W-1:0]   req_sub,
  output logic               req_crit,
  output logic [TAG_W-1:0]   req_tag,
  input  logic               ret_valid,
  input  logic [TAG_W-1:0]   ret_tag,
  input  logic [DATA_W-1:0]  ret_data,
  output logic               out_valid,
  output logic [LINE_AW-1:0] out_line,
  output logic [SUB_W-1:0]   out_sub,
  output logic [DATA_W-1:0]  out_data
);
  import csb_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic [ENTRIES-1:0]              ent_valid;
  logic [ENTRIES-1:0][LINE_AW-1:0] ent_line;
  logic [ENTRIES-1:0][NSUB-1:0]    ent_issued;
  logic [ENTRIES-1:0][NSUB-1:0]    ent_crit;
  logic [ENTRIES-1:0][ENTRIES-1:0] ent_older;
  logic                            line_hit;
  logic [ENT_W-1:0]                hit_idx;
  logic                            have_free;
  logic [ENT_W-1:0]                free_idx;
  logic [SUB_W-1:0]                miss_sub;
  logic                            alloc_ev;
  logic                            merge_ev;
  logic                            issue_ev;
  logic                            pick_valid;
  logic [ENT_W-1:0]                pick_idx;
  logic [SUB_W-1:0]                pick_sub;
  logic                            pick_crit;
  logic [ENT_W-1:0]                ret_idx;
  logic [SUB_W-1:0]                ret_sub;

  assign miss_sub   = SUB_W'(sub_of_offset(32'(miss_off), SUB_BYTES));
  assign miss_ready = line_hit || have_free;
  assign merge_ev   = miss_valid && line_hit;
  assign alloc_ev   = miss_valid && !line_hit && have_free;
  assign issue_ev   = pick_valid && req_ready;
  assign ret_idx    = ret_tag[TAG_W-1:SUB_W];
  assign ret_sub    = ret_tag[SUB_W-1:0];

  csb_mshr #(.LINE_AW(LINE_AW), .ENTRIES(ENTRIES), .NSUB(NSUB)) mshr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_line(miss_line),
    .alloc_en   (alloc_ev),
    .alloc_sub  (miss_sub),
    .merge_en   (merge_ev),
    .merge_idx  (hit_idx),
    .merge_sub  (miss_sub),
    .issue_en   (issue_ev),
    .issue_idx  (pick_idx),
    .issue_sub  (pick_sub),
    .ret_en     (ret_valid),
    .ret_idx    (ret_idx),
    .ret_sub    (ret_sub),
    .ent_valid  (ent_valid),
    .ent_line   (ent_line),
    .ent_issued (ent_issued),
    .ent_crit   (ent_crit),
    .ent_older  (ent_older),
    .line_hit   (line_hit),
    .hit_idx    (hit_idx),
    .have_free  (have_free),
    .free_idx   (free_idx)
  );

  csb_pick #(.ENTRIES(ENTRIES), .NSUB(NSUB)) pick_i (
    .ent_valid (ent_valid),
    .ent_issued(ent_issued),
    .ent_crit  (ent_crit),
    .ent_older (ent_older),
    .pick_valid(pick_valid),
    .pick_idx  (pick_idx),
    .pick_sub  (pick_sub),
    .pick_crit (pick_crit)
  );

  assign req_valid = pick_valid;
  assign req_line  = ent_line[pick_idx];
  assign req_sub   = pick_sub;
  assign req_crit  = pick_crit;
  assign req_tag   = {pick_idx, pick_sub};

  csb_retpath #(.LINE_AW(LINE_AW), .SUB_W(SUB_W), .DATA_W(DATA_W)) ret_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ret_en   (ret_valid),
    .ret_line (ent_line[ret_idx]),
    .ret_sub  (ret_sub),
    .ret_data (ret_data),
    .out_valid(out_valid),
    .out_line (out_line),
    .out_sub  (out_sub),
    .out_data (out_data)
  );

endmodule

// File: rtl/subblock_prio_splitter_chk.sv
module subblock_prio_splitter_chk #(
  parameter int ENTRIES = 4,
  parameter int NSUB    = 4,
  parameter int SUB_W   = 2,
  parameter int TAG_W   = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         miss_valid,
  input logic                         miss_ready,
  input logic                         line_hit,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic                         req_crit,
  input logic [TAG_W-1:0]             req_tag,
  input logic                         ret_valid,
  input logic [TAG_W-1:0]             ret_tag,
  input logic                         out_valid,
  input logic [SUB_W-1:0]             out_sub,
  input logic [ENTRIES-1:0]           ent_valid,
  input logic [ENTRIES-1:0][NSUB-1:0] ent_issued,
  input logic [ENTRIES-1:0][NSUB-1:0] ent_crit
);

  logic crit_waiting;
  always_comb begin
    crit_waiting = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      for (int s = 0; s < NSUB; s++) begin
        if (ent_valid[i] && ent_crit[i][s] && !ent_issued[i][s]) crit_waiting = 1'b1;
      end
    end
  end

  p_crit_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && crit_waiting) |-> req_crit);

  p_issue_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !(req_valid && req_tag == $past(req_tag)));

  p_merge_no_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && line_hit && !ret_valid)
      |=> $countones(ent_valid) == $countones($past(ent_valid)));

  p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_valid && !line_hit) |-> !miss_ready);

  p_ret_to_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (out_valid && out_sub == $past(ret_tag[SUB_W-1:0])));

  p_quiet_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> !out_valid);

endmodule

bind subblock_prio_splitter subblock_prio_splitter_chk #(
  .ENTRIES(ENTRIES), .NSUB(NSUB), .SUB_W(SUB_W), .TAG_W(TAG_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .miss_valid(miss_valid),
  .miss_ready(miss_ready),
  .line_hit  (line_hit),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_crit  (req_crit),
  .req_tag   (req_tag),
  .ret_valid (ret_valid),
  .ret_tag   (ret_tag),
  .out_valid (out_valid),
  .out_sub   (out_sub),
  .ent_valid (ent_valid),
  .ent_issued(ent_issued),
  .ent_crit  (ent_crit)
);

// File: tb/subblock_prio_splitter_tb_top.sv
`timescale 1ns/1ps
module subblock_prio_splitter_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic         miss_ready;
  logic [25:0]  miss_line = '0;
  logic [5:0]   miss_off = '0;
  logic         req_valid;
  logic         req_ready = 1'b0;
  logic [25:0]  req_line;
  logic [1:0]   req_sub;
  logic         req_crit;
  logic [3:0]   req_tag;
  logic         ret_valid = 1'b0;
  logic [3:0]   ret_tag = '0;
  logic [127:0] ret_data = '0;
  logic         out_valid;
  logic [25:0]  out_line;
  logic [1:0]   out_sub;
  logic [127:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  subblock_prio_splitter dut_i (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_line(miss_line), .miss_off(miss_off),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .req_sub(req_sub), .req_crit(req_crit), .req_tag(req_tag),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data),
    .out_valid(out_valid), .out_line(out_line), .out_sub(out_sub),
    .out_data(out_data)
  );

  function automatic logic [127:0] mk_data(logic [3:0] tag);
    return {8{12'hC5A, tag}};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_miss(logic [25:0] l, logic [5:0] o, bit exp_ready, string req);
    @(negedge clk);
    miss_valid = 1'b1; miss_line = l; miss_off = o;
    #1;
    chk(miss_ready == exp_ready, req, "miss_ready on miss", 128'(miss_ready), 128'(exp_ready));
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic peek_ready(logic [25:0] l, bit exp_ready, string req);
    @(negedge clk);
    miss_line = l;
    #1;
    chk(miss_ready == exp_ready, req, "miss_ready peek", 128'(miss_ready), 128'(exp_ready));
  endtask

  task automatic expect_req(logic [25:0] l, logic [1:0] s, bit c, logic [3:0] tag, string req);
    @(negedge clk);
    chk(req_valid && {req_line, req_sub, req_crit, req_tag} == {l, s, c, tag}, req,
        "request {valid,line,sub,crit,tag}",
        128'({req_valid, req_line, req_sub, req_crit, req_tag}),
        128'({1'b1, l, s, c, tag}));
    req_ready = 1'b1;
  endtask

  task automatic end_reqs(string req);
    @(negedge clk);
    req_ready = 1'b0;
    chk(!req_valid, req, "no further request", 128'(req_valid), 128'(0));
  endtask

  task automatic do_ret(logic [3:0] tag, logic [25:0] l, string req);
    @(negedge clk);
    ret_valid = 1'b1; ret_tag = tag; ret_data = mk_data(tag);
    @(negedge clk);
    ret_valid = 1'b0;
    chk(out_valid && out_line == l && out_sub == tag[1:0] && out_data == mk_data(tag), req,
        "delivered {valid,line,sub} / data",
        128'({out_valid, out_line, out_sub}), 128'({1'b1, l, tag[1:0]}));
    chk(out_data == mk_data(tag), req, "delivered data", out_data, mk_data(tag));
  endtask

  // R9: reset state
  task automatic t_reset;
    @(negedge clk);
    chk(!req_valid, "R9", "req_valid after reset", 128'(req_valid), 128'(0));
    chk(!out_valid, "R9", "out_valid after reset", 128'(out_valid), 128'(0));
    #1;
    chk(miss_ready, "R9", "miss_ready after reset", 128'(miss_ready), 128'(1));
  endtask

  // R1, R2, R6, R7: one line, offset 40 -> sub-block 2 critical
  task automatic t_single;
    send_miss(26'h100, 6'd40, 1'b1, "R5");
    expect_req(26'h100, 2'd2, 1'b1, 4'd2, "R2");
    expect_req(26'h100, 2'd0, 1'b0, 4'd0, "R1");
    expect_req(26'h100, 2'd1, 1'b0, 4'd1, "R1");
    expect_req(26'h100, 2'd3, 1'b0, 4'd3, "R1");
    end_reqs("R1");
    do_ret(4'd2, 26'h100, "R6");
    do_ret(4'd0, 26'h100, "R6");
    do_ret(4'd1, 26'h100, "R6");
    do_ret(4'd3, 26'h100, "R7");
    @(negedge clk);
    chk(!out_valid, "R6", "out_valid idle after return", 128'(out_valid), 128'(0));
  endtask

  // R3: critical class first across lines, oldest first, then lowest index
  task automatic t_two_lines;
    send_miss(26'h200, 6'd5, 1'b1, "R5");
    send_miss(26'h300, 6'd50, 1'b1, "R5");
    expect_req(26'h200, 2'd0, 1'b1, 4'd0, "R3");
    expect_req(26'h300, 2'd3, 1'b1, 4'd7, "R3");
    expect_req(26'h200, 2'd1, 1'b0, 4'd1, "R3");
    expect_req(26'h200, 2'd2, 1'b0, 4'd2, "R3");
    expect_req(26'h200, 2'd3, 1'b0, 4'd3, "R3");
    expect_req(26'h300, 2'd0, 1'b0, 4'd4, "R3");
    expect_req(26'h300, 2'd1, 1'b0, 4'd5, "R3");
    expect_req(26'h300, 2'd2, 1'b0, 4'd6, "R3");
    end_reqs("R3");
    do_ret(4'd6, 26'h300, "R7");
    do_ret(4'd0, 26'h200, "R7");
    do_ret(4'd7, 26'h300, "R7");
    do_ret(4'd1, 26'h200, "R7");
    do_ret(4'd2, 26'h200, "R7");
    do_ret(4'd4, 26'h300, "R7");
    do_ret(4'd3, 26'h200, "R7");
    do_ret(4'd5, 26'h300, "R7");
  endtask

  // R4: a second miss promotes an unissued sub-block, a third on an issued one does nothing
  task automatic t_merge;
    send_miss(26'h400, 6'd0, 1'b1, "R5");
    send_miss(26'h400, 6'd33, 1'b1, "R4");
    expect_req(26'h400, 2'd0, 1'b1, 4'd0, "R4");
    expect_req(26'h400, 2'd2, 1'b1, 4'd2, "R4");
    expect_req(26'h400, 2'd1, 1'b0, 4'd1, "R4");
    expect_req(26'h400, 2'd3, 1'b0, 4'd3, "R4");
    end_reqs("R4");
    send_miss(26'h400, 6'd20, 1'b1, "R4");
    @(negedge clk);
    chk(!req_valid, "R4", "merge on issued sub-block adds no request", 128'(req_valid), 128'(0));
    do_ret(4'd3, 26'h400, "R7");
    do_ret(4'd1, 26'h400, "R7");
    do_ret(4'd2, 26'h400, "R7");
    do_ret(4'd0, 26'h400, "R7");
  endtask

  // R8, R5, R7, R3: full table, stall, free one entry, re-allocate it
  task automatic t_full;
    for (int e = 0; e < 4; e++) send_miss(26'h500 + 26'(e), 6'd0, 1'b1, "R5");
    send_miss(26'h600, 6'd63, 1'b0, "R8");
    send_miss(26'h502, 6'd20, 1'b1, "R4");
    expect_req(26'h500, 2'd0, 1'b1, 4'd0,  "R3");
    expect_req(26'h501, 2'd0, 1'b1, 4'd4,  "R3");
    expect_req(26'h502, 2'd0, 1'b1, 4'd8,  "R3");
    expect_req(26'h502, 2'd1, 1'b1, 4'd9,  "R3");
    expect_req(26'h503, 2'd0, 1'b1, 4'd12, "R3");
    expect_req(26'h500, 2'd1, 1'b0, 4'd1,  "R3");
    expect_req(26'h500, 2'd2, 1'b0, 4'd2,  "R3");
    expect_req(26'h500, 2'd3, 1'b0, 4'd3,  "R3");
    expect_req(26'h501, 2'd1, 1'b0, 4'd5,  "R3");
    expect_req(26'h501, 2'd2, 1'b0, 4'd6,  "R3");
    expect_req(26'h501, 2'd3, 1'b0, 4'd7,  "R3");
    expect_req(26'h502, 2'd2, 1'b0, 4'd10, "R3");
    expect_req(26'h502, 2'd3, 1'b0, 4'd11, "R3");
    expect_req(26'h503, 2'd1, 1'b0, 4'd13, "R3");
    expect_req(26'h503, 2'd2, 1'b0, 4'd14, "R3");
    expect_req(26'h503, 2'd3, 1'b0, 4'd15, "R3");
    end_reqs("R1");
    do_ret(4'd5, 26'h501, "R6");
    do_ret(4'd4, 26'h501, "R6");
    do_ret(4'd6, 26'h501, "R6");
    peek_ready(26'h600, 1'b0, "R7");
    do_ret(4'd7, 26'h501, "R7");
    peek_ready(26'h600, 1'b1, "R7");
    send_miss(26'h600, 6'd63, 1'b1, "R5");
    expect_req(26'h600, 2'd3, 1'b1, 4'd7, "R5");
    expect_req(26'h600, 2'd0, 1'b0, 4'd4, "R5");
    expect_req(26'h600, 2'd1, 1'b0, 4'd5, "R5");
    expect_req(26'h600, 2'd2, 1'b0, 4'd6, "R5");
    end_reqs("R1");
    for (int t = 0; t < 16; t++) begin
      logic [25:0] l;
      l = (t / 4 == 1) ? 26'h600 : 26'h500 + 26'(t / 4);
      do_ret(4'(15 - t), (t / 4 == 2) ? 26'h600 : 26'h500 + 26'(3 - t / 4), "R7");
    end
    peek_ready(26'h700, 1'b1, "R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_two_lines();
    t_merge();
    t_full();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule